// File: doc/BRIEF.md
# Transport Frame Aligner

The aligner sits after the convolutional decoder. It receives the decoded stream one bit at a time, finds where bytes and transport blocks begin, and passes on byte-wide data with a start-of-block marker. Before it declares alignment it needs a run of sync bytes, each exactly one block length after the previous one. A single pattern match is not enough. While it searches, every bit offset is a candidate. Once locked, it looks only at the bit position where the next sync byte should end.

It has two framing modes. In full mode a block is 204 bytes and all of them go downstream, the sync byte first. In strip mode a block is 147 bytes, the sync value comes from an input port, and the sync byte is removed, so 146 bytes per block go downstream. The decoder can leave the stream bit-inverted because of a 180-degree carrier ambiguity. The aligner detects this from the polarity of the sync bytes it sees during acquisition and complements the data it outputs. De-interleaving and error correction happen in later blocks.

Top module: `frame_aligner`

## Requirements
- R1: A bit is taken only in a cycle with `bit_valid` high. The first bit taken for a byte becomes its MSB. Cycles with `bit_valid` low change nothing, whatever `bit_in` does.
- R2: While unlocked, the aligner tests every bit offset for a sync match. `locked` rises on the clock edge that takes the last bit of the third sync byte (LOCK_CNT) in an unbroken run, where each sync byte ends exactly one block length in bits after the previous one. At an expected sync position, a non-sync byte breaks the run and the search starts again.
- R3: With `mode` = 0 (full mode), a block is LEN_A bytes (default 204). A sync byte is 0x47, or its complement 0xB8, which normally appears on every eighth block. Every byte is passed on, and `block_start` marks the sync byte.
- R4: With `mode` = 1 (strip mode), a block is LEN_B bytes (default 147). A sync byte equals `sync_val` or its complement. The sync byte is never output, so LEN_B-1 bytes per block are output, and `block_start` marks the first byte after the sync.
- R5: Among the LOCK_CNT sync bytes that establish lock, a byte that matches the complement of the mode's sync value counts as inverted. If more than half are inverted, every output byte is bit-complemented. This polarity decision does not change while lock holds.
- R6: While locked, a sync byte missing at its expected position adds one to a miss count, and a correct sync byte clears that count. Bytes of a block whose sync is missing are still output, with `block_start`. The fourth consecutive miss (LOSS_CNT) drops `locked` on the edge that takes that sync position's last bit. That byte is not output.
- R7: `byte_valid` is high only while `locked` is high. Output begins with the block whose sync completes the lock: with its sync byte in full mode, or with its first data byte in strip mode.
- R8: `byte_valid` is a one-cycle pulse that appears on the clock edge that takes the last bit of the byte.
- R9: During and straight after reset, `locked`, `byte_valid` and `block_start` are 0. No sync match is possible until eight bits have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Decoded serial data bit |
| bit_valid | input | 1 | `bit_in` carries a bit this cycle |
| mode | input | 1 | 0 selects full framing, 1 selects strip framing |
| sync_val | input | 8 | Sync byte value used in strip mode |
| byte_out | output | 8 | Aligned byte, with polarity corrected |
| byte_valid | output | 1 | `byte_out` holds a new byte this cycle |
| block_start | output | 1 | First output byte of a block |
| locked | output | 1 | Block alignment is established |

## Verification
The bench builds the aligner with LEN_A = 24 and LEN_B = 19, and keeps LOCK_CNT = 3 and LOSS_CNT = 4. Short blocks let one short run cover several complete acquisitions in both modes and both polarities. They also let it walk through the loss sequence: three misses that a good sync then clears, followed by four misses that drop lock. The data bytes are drawn from values with few set bits, so that no false sync can appear at any bit offset. The expected lock instant is therefore exact and can be checked on the edge.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } fa_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/fa_window.sv
// Sliding bit window with sync / complemented-sync comparison.
module fa_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_valid,
  input  logic [W-1:0] ref_sync,
  output logic [W-1:0] win,
  output logic         hit_true,
  output logic         hit_comp
);
  localparam int FW = (W > 2) ? $clog2(W) : 1;
  localparam logic [FW-1:0] FILL_MAX = FW'(W - 1);

  logic [W-2:0]  sr_q, sr_d;
  logic [FW-1:0] fill_q, fill_d;
  logic          full;

  assign full = (fill_q == FILL_MAX);

  always_comb begin
    win    = {sr_q, bit_in};
    sr_d   = win[W-2:0];
    fill_d = full ? fill_q : fill_q + 1'b1;
  end

  assign hit_true = bit_valid && full && (win == ref_sync);
  assign hit_comp = bit_valid && full && (win == ~ref_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (bit_valid) begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/fa_track.sv
// Search / verify / lock sequencer, block position counter and polarity vote.
module fa_track #(
  parameter int W        = 8,
  parameter int LEN_A    = 204,
  parameter int LEN_B    = 147,
  parameter int LOCK_CNT = 3,
  parameter int LOSS_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic mode_strip,
  input  logic hit_true,
  input  logic hit_comp,
  output logic locked,
  output logic pol,
  output logic emit,
  output logic start
);
  import fa_pkg::*;

  localparam int BITS_A = LEN_A * W;
  localparam int BITS_B = LEN_B * W;
  localparam int PW     = $clog2(BITS_A);
  localparam int LW     = $clog2(W);
  localparam int HW     = $clog2(LOCK_CNT + 1);
  localparam int MW     = $clog2(LOSS_CNT + 1);
  localparam logic [PW-1:0] LAST_A    = PW'(BITS_A - 1);
  localparam logic [PW-1:0] LAST_B    = PW'(BITS_B - 1);
  localparam logic [PW-1:0] FIRST_END = PW'(W - 1);
  localparam logic [HW-1:0] HITS_FULL = HW'(LOCK_CNT - 1);
  localparam logic [HW:0]   LOCK_K    = (HW + 1)'(LOCK_CNT);
  localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_CNT - 1);

  fa_state_e     state_q, state_d;
  logic [PW-1:0] pos_q, pos_d, pos_step, blk_last;
  logic [HW-1:0] hits_q, hits_d, comps_q, comps_d, comps_sum;
  logic [MW-1:0] miss_q, miss_d;
  logic          pol_q, pol_d;
  logic          hit, at_sync, byte_end, live, lock_now, drop_now;

  assign blk_last  = mode_strip ? LAST_B : LAST_A;
  assign hit       = hit_true | hit_comp;
  assign at_sync   = (state_q == ST_SEARCH) || (pos_q == blk_last);
  assign pos_step  = (pos_q == blk_last) ? '0 : pos_q + 1'b1;
  assign comps_sum = comps_q + HW'(hit_comp);

  // next-state process
  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    hits_d   = hits_q;
    comps_d  = comps_q;
    miss_d   = miss_q;
    pol_d    = pol_q;
    lock_now = 1'b0;
    drop_now = 1'b0;
    if (bit_valid) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (hit) begin
            pos_d   = '0;
            hits_d  = HW'(1);
            comps_d = comps_sum;
            if (hits_q == HITS_FULL) lock_now = 1'b1;
            else                     state_d  = ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          pos_d = pos_step;
          if (at_sync) begin
            if (hit) begin
              hits_d  = hits_q + 1'b1;
              comps_d = comps_sum;
              if (hits_q == HITS_FULL) lock_now = 1'b1;
            end else begin
              state_d = ST_SEARCH;
              hits_d  = '0;
              comps_d = '0;
            end
          end
        end
        ST_LOCKED: begin
          pos_d = pos_step;
          if (at_sync) begin
            if (hit) begin
              miss_d = '0;
            end else if (miss_q == MISS_LAST) begin
              drop_now = 1'b1;
              state_d  = ST_SEARCH;
              miss_d   = '0;
              hits_d   = '0;
              comps_d  = '0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
        default: state_d = ST_SEARCH;
      endcase
      if (lock_now) begin
        state_d = ST_LOCKED;
        miss_d  = '0;
        hits_d  = '0;
        comps_d = '0;
        pol_d   = ({comps_sum, 1'b0} > LOCK_K);
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      hits_q  <= '0;
      comps_q <= '0;
      miss_q  <= '0;
      pol_q   <= 1'b0;
    end else if (bit_valid) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      hits_q  <= hits_d;
      comps_q <= comps_d;
      miss_q  <= miss_d;
      pol_q   <= pol_d;
    end
  end

  assign byte_end = (state_q == ST_SEARCH) || (pos_q[LW-1:0] == LW'(W - 1));
  assign live     = (state_q == ST_LOCKED) || lock_now;
  assign emit     = bit_valid && byte_end && live && !drop_now &&
                    !(mode_strip && at_sync);
  assign start    = mode_strip ? (pos_q == FIRST_END) : at_sync;
  assign pol      = lock_now ? pol_d : pol_q;
  assign locked   = (state_q == ST_LOCKED);

  AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(hits_q) == HITS_FULL)); // R2

  AST_LOSS_AFTER_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(miss_q) == MISS_LAST)); // R6

  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(pol_q)); // R5
endmodule

// File: rtl/fa_emit.sv
// Output register stage: polarity correction, valid and block-start marking.
module fa_emit #(
  parameter int W     = 8,
  parameter int LEN_A = 204,
  parameter int LEN_B = 147
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] win,
  input  logic         pol,
  input  logic         emit,
  input  logic         start,
  input  logic         locked,
  input  logic         mode_strip,
  output logic [W-1:0] byte_out,
  output logic         byte_valid,
  output logic         block_start
);
  localparam int CW = $clog2(LEN_A + 1);

  logic [W-1:0] data_q, data_d;
  logic         valid_q, start_q;

  assign data_d = pol ? ~win : win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (emit) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      valid_q <= emit;
      start_q <= emit && start;
    end
  end

  assign byte_out    = data_q;
  assign byte_valid  = valid_q;
  assign block_start = start_q;

  // block length observer for the assertions below
  logic [CW-1:0] cnt_q, out_len;
  logic          seen_q;

  assign out_len = mode_strip ? CW'(LEN_B - 1) : CW'(LEN_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!locked) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_q) begin
      cnt_q  <= start_q ? CW'(1) : cnt_q + 1'b1;
      seen_q <= seen_q | start_q;
    end
  end

  AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> locked); // R7

  AST_BLOCK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && block_start && seen_q) |-> (cnt_q == out_len)); // R3

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !block_start) |-> (cnt_q < out_len)); // R4
endmodule

// File: rtl/frame_aligner.sv
// Transport frame aligner top level.
module frame_aligner #(
  parameter int          LEN_A    = 204,
  parameter int          LEN_B    = 147,
  parameter int          LOCK_CNT = 3,
  parameter int          LOSS_CNT = 4,
  parameter logic [7:0]  SYNC_A   = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_valid,
  input  logic       mode,
  input  logic [7:0] sync_val,
  output logic [7:0] byte_out,
  output logic       byte_valid,
  output logic       block_start,
  output logic       locked
);
  localparam int W = fa_pkg::BYTE_W;

  logic [W-1:0] ref_sync, win;
  logic         hit_true, hit_comp, pol, emit, start;

  assign ref_sync = mode ? sync_val : SYNC_A;

  fa_window #(.W(W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .bit_valid(bit_valid),
    .ref_sync (ref_sync),
    .win      (win),
    .hit_true (hit_true),
    .hit_comp (hit_comp)
  );

  fa_track #(
    .W(W), .LEN_A(LEN_A), .LEN_B(LEN_B),
    .LOCK_CNT(LOCK_CNT), .LOSS_CNT(LOSS_CNT)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .mode_strip(mode),
    .hit_true  (hit_true),
    .hit_comp  (hit_comp),
    .locked    (locked),
    .pol       (pol),
    .emit      (emit),
    .start     (start)
  );

  fa_emit #(.W(W), .LEN_A(LEN_A), .LEN_B(LEN_B)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .pol        (pol),
    .emit       (emit),
    .start      (start),
    .locked     (locked),
    .mode_strip (mode),
    .byte_out   (byte_out),
    .byte_valid (byte_valid),
    .block_start(block_start)
  );

  AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_valid)); // R8
endmodule

// File: tb/sim_frame_aligner.sv
module sim_frame_aligner;
  localparam int LA = 24;
  localparam int LB = 19;

  logic       clk = 1'b0;
  logic       rst_n, bit_in, bit_valid, mode;
  logic [7:0] sync_val, byte_out;
  logic       byte_valid, block_start, locked;

  always #5 clk = ~clk;

  frame_aligner #(.LEN_A(LA), .LEN_B(LB), .LOCK_CNT(3), .LOSS_CNT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .mode(mode), .sync_val(sync_val), .byte_out(byte_out),
    .byte_valid(byte_valid), .block_start(block_start), .locked(locked)
  );

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         gaps   = 1'b0;
  bit         done   = 1'b0;
  string      cur_req = "R3";
  logic [8:0] exp_q[$];
  logic [8:0] mon_e;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: one pop per valid output cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && byte_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected output byte", int'({block_start, byte_out}), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({block_start, byte_out} == mon_e, cur_req, "start/byte",
            int'({block_start, byte_out}), int'(mon_e));
      end
    end
  end

  function automatic logic [7:0] data_of(input int blk, input int j);
    return 8'((blk * 5 + j * 3) % 6);
  endfunction

  task automatic send_bit(input logic b, input bit chk_v);
    bit_in    = b;
    bit_valid = 1'b1;
    @(posedge clk); #1;
    if (chk_v) chk(byte_valid == 1'b1, "R8", "byte_valid on last bit edge", int'(byte_valid), 1);
    if (gaps) begin
      bit_valid = 1'b0;
      bit_in    = ~b;  // R1: toggling while invalid must be ignored
      @(posedge clk); #1;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit inv, input bit exp_on, input bit exp_st);
    if (exp_on) exp_q.push_back({exp_st, v});
    for (int i = 7; i >= 0; i--) send_bit(v[i] ^ inv, exp_on && (i == 0));
  endtask

  task automatic send_pre(input int n, input bit inv);
    for (int i = 0; i < n; i++) send_bit(inv, 1'b0);
  endtask

  task automatic send_block(input logic [7:0] sync, input bit inv, input bit emit,
                            input int blk, input int lk, input string lreq);
    send_byte(sync, inv, emit && !mode, 1'b1);
    if (lk >= 0) chk(locked == lk[0], lreq, "locked after sync byte", int'(locked), lk);
    for (int j = 0; j < (mode ? LB - 1 : LA - 1); j++)
      send_byte(data_of(blk, j), inv, emit, mode && (j == 0));
  endtask

  task automatic do_reset();
    chk(exp_q.size() == 0, "R7", "expected bytes left over", exp_q.size(), 0);
    exp_q.delete();
    bit_valid = 1'b0;
    bit_in    = 1'b0;
    rst_n     = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk(locked == 1'b0,      "R9", "locked in reset",      int'(locked), 0);
    chk(byte_valid == 1'b0,  "R9", "byte_valid in reset",  int'(byte_valid), 0);
    chk(block_start == 1'b0, "R9", "block_start in reset", int'(block_start), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(locked == 1'b0, "R9", "locked after reset", int'(locked), 0);
  endtask

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; mode = 1'b0; sync_val = 8'hE4;

    // full mode, normal polarity, lock then loss sequence (R2 R3 R6)
    cur_req = "R3"; mode = 1'b0; gaps = 1'b0;
    do_reset();
    send_pre(3, 1'b0);
    send_block(8'hB8, 1'b0, 1'b0, 0, 0, "R2");
    send_block(8'h47, 1'b0, 1'b0, 1, 0, "R2");
    send_block(8'h47, 1'b0, 1'b1, 2, 1, "R2");
    for (int b = 3; b < 6; b++) send_block(8'h47, 1'b0, 1'b1, b, 1, "R3");
    for (int b = 6; b < 9; b++) send_block(8'h05, 1'b0, 1'b1, b, 1, "R6");
    send_block(8'h47, 1'b0, 1'b1, 9, 1, "R6");
    for (int b = 10; b < 13; b++) send_block(8'h05, 1'b0, 1'b1, b, 1, "R6");
    send_block(8'h05, 1'b0, 1'b0, 13, 0, "R6");
    send_block(8'h47, 1'b0, 1'b0, 14, 0, "R7");
    bit_valid = 1'b0;
    repeat (4) @(posedge clk); #1;

    // full mode, inverted stream with idle gaps between bits (R1 R5)
    cur_req = "R1/R5"; gaps = 1'b1;
    do_reset();
    send_pre(5, 1'b1);
    send_block(8'h47, 1'b1, 1'b0, 0, 0, "R2");
    send_block(8'hB8, 1'b1, 1'b0, 1, 0, "R2");
    send_block(8'h47, 1'b1, 1'b1, 2, 1, "R5");
    send_block(8'h47, 1'b1, 1'b1, 3, 1, "R5");
    send_block(8'hB8, 1'b1, 1'b1, 4, 1, "R5");
    gaps = 1'b0; bit_valid = 1'b0;
    repeat (4) @(posedge clk); #1;

    // strip mode, normal polarity (R4)
    cur_req = "R4"; mode = 1'b1; sync_val = 8'hE4;
    do_reset();
    send_block(8'hE4, 1'b0, 1'b0, 0, 0, "R2");
    send_block(8'hE4, 1'b0, 1'b0, 1, 0, "R2");
    for (int b = 2; b < 5; b++) send_block(8'hE4, 1'b0, 1'b1, b, 1, "R4");
    bit_valid = 1'b0;
    repeat (4) @(posedge clk); #1;

    // strip mode, inverted stream (R4 R5)
    cur_req = "R4/R5";
    do_reset();
    send_pre(6, 1'b1);
    send_block(8'hE4, 1'b1, 1'b0, 0, 0, "R2");
    send_block(8'hE4, 1'b1, 1'b0, 1, 0, "R2");
    for (int b = 2; b < 4; b++) send_block(8'hE4, 1'b1, 1'b1, b, 1, "R5");
    bit_valid = 1'b0;
    repeat (4) @(posedge clk); #1;

    chk(exp_q.size() == 0, "R7", "expected bytes left over", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule